// File: doc/BRIEF.md
# Vector Indexed Register Gather Unit

This block runs a vector "move indexed" operation on its own 128-entry element register file, one element after another. A start strobe supplies the destination base, the index base, the source base and the vector length. For each element `i` from 0 up to length-1, the unit reads an index from the index base plus `i` and keeps its low seven bits. It then checks that the index is below the vector length. If it is, the unit copies the entry at the source base plus the index into the destination base plus `i`. Every register address wraps modulo 128.

Each element takes two cycles. The first cycle reads and checks the index, and the second reads the source and writes the destination. The first index that is not below the length ends the run with a trap, which reports the element number that failed. Elements finished before the trap keep their new values.

An issue stage can read a conservative read-dependency window from the moment the operation is accepted. The window covers the source registers from the source base, with its size rounded up to a power of two, and computing it needs no register-file read. A test port loads and observes the register file while the unit is idle.

Top module: `gather_unit`

## Requirements
- R1: After reset, `busy`, `done` and `trap` are low and `dep_mask` is all zeros.
- R2: While the unit is idle, a `tst_we` pulse writes `tst_wdata` to entry `tst_addr` at the clock edge. `tst_rdata` always shows the current content of entry `tst_addr` without a clock delay.
- R3: Elements are handled in increasing order of `i`. The index is bits 6:0 of entry (`idx_base`+i) mod 128, and bits 31:7 are ignored. Entry (`rd_base`+i) mod 128 receives entry (`src_base`+index) mod 128. A later element sees the writes of earlier elements.
- R4: The first element whose index is not below `vlen` writes nothing, and no later element runs. Earlier writes are kept. `trap` is high in the `done` cycle only, and `trap_elem` then holds that element number.
- R5: An accepted start with `vlen`=N≥1 gives `done` for exactly one cycle, 2·N clock edges after the start edge, or 2·k+1 edges after it when the run traps at element k. `busy` is high from the cycle after the start edge through the `done` cycle and low in the next cycle.
- R6: A start with `vlen`=0 raises `done` in the cycle right after the start edge, with no trap and no register write.
- R7: From the cycle after an accepted start through the `done` cycle, bit (`src_base`+j) mod 128 of `dep_mask` is set exactly for j < P. P is the smallest power of two not below `vlen`, and P=0 when `vlen`=0. `dep_mask` is zero while `busy` is low.
- R8: A start while `busy` is high, including the `done` cycle, is ignored. The running operation's result and timing are unchanged.
- R9: A `tst_we` pulse while `busy` is high is ignored, and the addressed entry keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted only when idle |
| rd_base | input | 7 | Destination base register |
| idx_base | input | 7 | Index base register |
| src_base | input | 7 | Source base register |
| vlen | input | 7 | Vector length, 0 to 64 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | Out-of-range index, valid with done |
| trap_elem | output | 7 | Element number that trapped |
| dep_mask | output | 128 | Read-dependency window over the registers |
| tst_we | input | 1 | Test-port write enable |
| tst_addr | input | 7 | Test-port address |
| tst_wdata | input | 32 | Test-port write data |
| tst_rdata | output | 32 | Test-port read data |

## Verification
The assertions assume that `vlen` never exceeds 64 when a start is accepted, and that reset is asserted before the first start. They do not assume that start is quiet while busy, because an ignored start is part of the behaviour being checked. The stimulus keeps every vector length between 0 and 64, and it deliberately drives a start strobe and a test write during a run. Overlapping destination, index and source windows are left in the stimulus on purpose, and the bench's sequential model decides the expected outcome.

// File: rtl/gather_pkg.sv
`timescale 1ns/1ps
package gather_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 7;
    localparam int VL_MAX = 64;
    localparam int VL_W   = $clog2(VL_MAX + 1);
    localparam int NREG   = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] raddr_t;
    typedef logic [VL_W-1:0]   vlen_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INDEX,
        ST_FETCH,
        ST_FINISH
    } gstate_e;

    typedef struct packed {
        raddr_t dst;
        raddr_t idx;
        raddr_t src;
        vlen_t  len;
    } gop_t;

    function automatic raddr_t wrap_add(raddr_t a, raddr_t b);
        return a + b;
    endfunction

    function automatic raddr_t low_index(word_t w);
        return w[ADDR_W-1:0];
    endfunction
endpackage

// File: rtl/gather_rf.sv
`timescale 1ns/1ps
module gather_rf #(
    parameter int DW  = 32,
    parameter int AW  = 7,
    parameter int NRD = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra [NRD],
    output logic [DW-1:0] rdat [NRD]
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa] <= wd;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdat[p] = mem[ra[p]];
    end
endmodule

// File: rtl/gather_win.sv
`timescale 1ns/1ps
module gather_win #(
    parameter int AW = 7,
    parameter int VW = 7
) (
    input  logic [AW-1:0]      base,
    input  logic [VW-1:0]      len,
    output logic [(1<<AW)-1:0] mask
);
    localparam int NR = 1 << AW;

    logic [AW:0] span;

    always_comb begin
        span = '0;
        if (len != '0) begin
            span = (AW+1)'(1);
            for (int k = 0; k < AW; k++) begin
                if (span < (AW+1)'(len)) begin
                    span = span << 1;
                end
            end
        end
        mask = '0;
        for (int j = 0; j < NR; j++) begin
            if ((AW+1)'(j) < span) begin
                mask[AW'(base + AW'(j))] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/gather_seq.sv
`timescale 1ns/1ps
module gather_seq
    import gather_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  gop_t   op_in,
    input  word_t  idx_word,
    output raddr_t idx_raddr,
    output raddr_t src_raddr,
    output logic   wr_en,
    output raddr_t wr_addr,
    output logic   accept,
    output logic   busy,
    output logic   done,
    output logic   trap,
    output raddr_t trap_elem
);
    gstate_e state_q;
    gop_t    op_q;
    raddr_t  elem_q;
    raddr_t  off_q;
    logic    trap_q;
    raddr_t  tidx_q;
    raddr_t  idx_val;

    assign idx_val = low_index(idx_word);
    assign accept  = (state_q == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            elem_q  <= '0;
            off_q   <= '0;
            trap_q  <= 1'b0;
            tidx_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q    <= op_in;
                        elem_q  <= '0;
                        trap_q  <= 1'b0;
                        tidx_q  <= '0;
                        state_q <= (op_in.len == '0) ? ST_FINISH : ST_INDEX;
                    end
                end
                ST_INDEX: begin
                    if (32'(idx_val) >= 32'(op_q.len)) begin
                        trap_q  <= 1'b1;
                        tidx_q  <= elem_q;
                        state_q <= ST_FINISH;
                    end else begin
                        off_q   <= idx_val;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (32'(elem_q) + 32'd1 >= 32'(op_q.len)) begin
                        state_q <= ST_FINISH;
                    end else begin
                        elem_q  <= elem_q + 1'b1;
                        state_q <= ST_INDEX;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign idx_raddr = wrap_add(op_q.idx, elem_q);
    assign src_raddr = wrap_add(op_q.src, off_q);
    assign wr_addr   = wrap_add(op_q.dst, elem_q);
    assign wr_en     = (state_q == ST_FETCH);
    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_FINISH);
    assign trap      = done && trap_q;
    assign trap_elem = tidx_q;
endmodule

// File: rtl/gather_unit.sv
`timescale 1ns/1ps
module gather_unit
    import gather_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [6:0]   rd_base,
    input  logic [6:0]   idx_base,
    input  logic [6:0]   src_base,
    input  logic [6:0]   vlen,
    output logic         busy,
    output logic         done,
    output logic         trap,
    output logic [6:0]   trap_elem,
    output logic [127:0] dep_mask,
    input  logic         tst_we,
    input  logic [6:0]   tst_addr,
    input  logic [31:0]  tst_wdata,
    output logic [31:0]  tst_rdata
);
    localparam int PORT_IDX = 0;
    localparam int PORT_SRC = 1;
    localparam int PORT_TST = 2;
    localparam int NPORTS   = 3;

    gop_t   op_in;
    raddr_t rf_ra [NPORTS];
    word_t  rf_rd [NPORTS];
    raddr_t idx_raddr;
    raddr_t src_raddr;
    raddr_t seq_wa;
    logic   seq_we;
    logic   accept;
    logic   rf_we;
    raddr_t rf_wa;
    word_t  rf_wd;
    logic [NREG-1:0] win_now;
    logic [NREG-1:0] dep_q;

    assign op_in = '{dst: rd_base, idx: idx_base, src: src_base, len: vlen};

    gather_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op_in     (op_in),
        .idx_word  (rf_rd[PORT_IDX]),
        .idx_raddr (idx_raddr),
        .src_raddr (src_raddr),
        .wr_en     (seq_we),
        .wr_addr   (seq_wa),
        .accept    (accept),
        .busy      (busy),
        .done      (done),
        .trap      (trap),
        .trap_elem (trap_elem)
    );

    assign rf_ra[PORT_IDX] = idx_raddr;
    assign rf_ra[PORT_SRC] = src_raddr;
    assign rf_ra[PORT_TST] = tst_addr;

    assign rf_we = seq_we || (tst_we && !busy);
    assign rf_wa = seq_we ? seq_wa : tst_addr;
    assign rf_wd = seq_we ? rf_rd[PORT_SRC] : tst_wdata;

    gather_rf #(
        .DW  (DATA_W),
        .AW  (ADDR_W),
        .NRD (NPORTS)
    ) u_rf (
        .clk  (clk),
        .we   (rf_we),
        .wa   (rf_wa),
        .wd   (rf_wd),
        .ra   (rf_ra),
        .rdat (rf_rd)
    );

    gather_win #(
        .AW (ADDR_W),
        .VW (VL_W)
    ) u_win (
        .base (src_base),
        .len  (vlen),
        .mask (win_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dep_q <= '0;
        end else if (accept) begin
            dep_q <= win_now;
        end else if (done) begin
            dep_q <= '0;
        end
    end

    assign dep_mask  = dep_q;
    assign tst_rdata = rf_rd[PORT_TST];
endmodule

// File: rtl/gather_unit_chk.sv
`timescale 1ns/1ps
module gather_unit_chk (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [6:0]   vlen,
    input logic         busy,
    input logic         done,
    input logic         trap,
    input logic [127:0] dep_mask
);
    p_start_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    p_trap_with_done_r4: assert property (@(posedge clk) disable iff (rst)
        trap |-> done);

    p_empty_run_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && vlen == 7'd0) |=> (done && !trap));

    p_mask_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dep_mask == '0));

    p_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(dep_mask));

    p_mask_pow2_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (($countones(dep_mask) & ($countones(dep_mask) - 1)) == 0));

    p_start_in_done_r8: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !busy);
endmodule

bind gather_unit gather_unit_chk u_chk (.*);

// File: tb/gather_unit_test.sv
`timescale 1ns/1ps
module gather_unit_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [6:0]   rd_base = '0, idx_base = '0, src_base = '0, vlen = '0;
    logic         busy, done, trap;
    logic [6:0]   trap_elem;
    logic [127:0] dep_mask;
    logic         tst_we = 1'b0;
    logic [6:0]   tst_addr = '0;
    logic [31:0]  tst_wdata = '0;
    logic [31:0]  tst_rdata;

    int tests = 0;
    int fails = 0;
    logic [31:0] mdl [128];

    always #2 clk = ~clk;

    gather_unit uut (.*);

    // entry: {dst, idx, src, len, trap_pos}; trap_pos 127 means none
    localparam int NVEC = 8;
    localparam logic [34:0] VEC [NVEC] = '{
        {7'd10,  7'd0,  7'd40,  7'd8,  7'd127},
        {7'd64,  7'd20, 7'd100, 7'd5,  7'd127},
        {7'd120, 7'd30, 7'd126, 7'd16, 7'd127},
        {7'd70,  7'd50, 7'd90,  7'd12, 7'd6},
        {7'd5,   7'd33, 7'd80,  7'd3,  7'd0},
        {7'd40,  7'd44, 7'd0,   7'd1,  7'd127},
        {7'd64,  7'd0,  7'd64,  7'd64, 7'd127},
        {7'd12,  7'd8,  7'd2,   7'd7,  7'd6}
    };

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic twr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        tst_we = 1'b1; tst_addr = a; tst_wdata = d;
        @(negedge clk);
        tst_we = 1'b0;
        mdl[a] = d;
    endtask

    task automatic fill(input logic [6:0] ib, input int n, input int tp);
        for (int k = 0; k < 128; k++) begin
            twr(7'(k), {8'(k * 7 + 3), 8'hA5, 8'(k), 8'(k * 13)});
        end
        for (int i = 0; i < n; i++) begin
            if (i == tp) twr(7'(ib + 7'(i)), 32'h0000_0080 | 32'(n));
            else         twr(7'(ib + 7'(i)), 32'hFFFF_FF80 | 32'((i * 5 + 3) % n));
        end
    endtask

    task automatic cmp_rf(input string req);
        int bad = -1;
        for (int k = 0; k < 128; k++) begin
            tst_addr = 7'(k);
            #0.1;
            if (bad < 0 && tst_rdata !== mdl[k]) bad = k;
        end
        if (bad < 0) chk(1'b1, req, 0, 0);
        else begin
            tst_addr = 7'(bad); #0.1;
            chk(1'b0, req, {96'd0, tst_rdata}, {96'd0, mdl[bad]});
        end
    endtask

    task automatic run_op(input logic [6:0] d, input logic [6:0] ib, input logic [6:0] sb,
                          input int n, input bit intrude);
        bit e_trap = 1'b0;
        int e_elem = 0;
        int e_n;
        int p = 0;
        int cnt = 0;
        logic [127:0] e_mask = '0;
        logic [31:0] keep127;
        // sequential reference model (R3, R4)
        for (int i = 0; i < n; i++) begin
            int ix = int'(mdl[7'(ib + 7'(i))][6:0]);
            if (ix >= n) begin e_trap = 1'b1; e_elem = i; break; end
            mdl[7'(d + 7'(i))] = mdl[7'(sb + 7'(ix))];
        end
        e_n = (n == 0) ? 0 : (e_trap ? 2 * e_elem + 1 : 2 * n);
        if (n != 0) begin p = 1; while (p < n) p = p * 2; end
        for (int j = 0; j < p; j++) e_mask[7'(sb + 7'(j))] = 1'b1;
        keep127 = mdl[127];

        @(negedge clk);
        start = 1'b1; rd_base = d; idx_base = ib; src_base = sb; vlen = 7'(n);
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R5 busy after start", busy, 1);
        chk(dep_mask === e_mask, "R7 dependency window", dep_mask, e_mask);
        while (!done && cnt < 400) begin
            if (intrude && cnt == 2) begin
                start = 1'b1; vlen = 7'd0; src_base = 7'd3;
                tst_we = 1'b1; tst_addr = 7'd127; tst_wdata = 32'h1234_5678;
            end
            @(negedge clk);
            cnt++;
            if (intrude && cnt == 3) begin start = 1'b0; tst_we = 1'b0; end
        end
        if (intrude) begin
            chk(cnt == e_n, "R8 timing kept despite start while busy", cnt, e_n);
            start = 1'b1;
        end else begin
            chk(cnt == e_n, n == 0 ? "R6 done latency" : "R5 done latency", cnt, e_n);
        end
        chk(trap === e_trap, "R4 trap flag", trap, e_trap);
        if (e_trap) chk(trap_elem === 7'(e_elem), "R4 trap element", trap_elem, e_elem);
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b0 && done === 1'b0, "R5 idle after done", {busy, done}, 0);
        chk(dep_mask === '0, "R7 mask cleared", dep_mask, 0);
        if (intrude) begin
            tst_addr = 7'd127; #0.1;
            chk(tst_rdata === keep127, "R9 test write while busy", tst_rdata, keep127);
        end
        cmp_rf(e_trap ? "R4 register file after trap" :
               (n == 0 ? "R6 register file unchanged" : "R3 register file contents"));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #0.1;
        // R1 reset state
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(done === 1'b0, "R1 done", done, 0);
        chk(trap === 1'b0, "R1 trap", trap, 0);
        chk(dep_mask === '0, "R1 dep_mask", dep_mask, 0);
        // R2 test port
        twr(7'd55, 32'hDEAD_BEEF);
        tst_addr = 7'd55; #0.1;
        chk(tst_rdata === 32'hDEAD_BEEF, "R2 test port readback", tst_rdata, 32'hDEAD_BEEF);

        for (int v = 0; v < NVEC; v++) begin
            logic [34:0] e = VEC[v];
            fill(e[27:21], int'(e[13:7]), int'(e[6:0]));
            run_op(e[34:28], e[27:21], e[20:14], int'(e[13:7]), 1'b0);
        end

        // R6 empty run
        fill(7'd0, 4, 127);
        run_op(7'd1, 7'd0, 7'd9, 0, 1'b0);

        // R8 and R9: start and test write during a run
        fill(7'd0, 8, 127);
        run_op(7'd10, 7'd0, 7'd40, 8, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule